// File: doc/BRIEF.md
# Serial Flash Status Register Unit

This block is the slave-side command logic of a serial flash device. It handles the three commands that reach the status register: read status, write enable and write status. It watches the SPI pins (clock, chip select and data in) by oversampling them with a faster system clock. Bits are taken on the rising edge of the serial clock, and response bits are placed on the falling edge, as in SPI mode 0. The serial output is driven only while a read-status response is being streamed; the rest of the time the output-enable pin is low, which tells the pad to float the line.

The unit holds the write-enable latch, a lock bit and a four-bit protect field. A write-status command is committed only in three cases together: the latch is set, no self-timed cycle is running, and the host raises chip select exactly after the eighth data bit. A commit loads the writable bits at once and starts a busy window of `WR_CYCLES` system clocks. While that window runs, status bit 0 reads 1. When the window ends, bit 0 returns to 0 and the write-enable latch is cleared. When the lock bit is set and the write-protect pin is held low, the part is hardware protected and every write-status command is refused.

The controller is a single state machine with seven states. ST_IDLE waits for chip select low and then goes to ST_OPCODE. ST_OPCODE collects eight bits. Its decode goes to ST_READ, to ST_WEN_ARM, to ST_WR_DATA, or to ST_DROP (unknown code, or a command not allowed now). ST_WR_DATA collects the data byte and then goes to ST_WR_ARM. In ST_WEN_ARM and ST_WR_ARM, one more serial clock rise cancels the command and goes to ST_DROP. A chip select rise commits the command. ST_READ streams the status. ST_DROP ignores everything. From every state, chip select high returns to ST_IDLE.

Top module: `sr_status_unit`

## Requirements
- R1: After reset the status byte reads 0x00 and `spi_miso_oe` is low.
- R2: Opcode 0x05 is accepted at any time, even during a busy cycle. After the eighth opcode bit, the status byte is sent MSB first and repeated with no gap while chip select stays low. Each repeat is a fresh copy of the status.
- R3: Opcode 0x06 sets the write-enable latch (status bit 1) only when chip select rises directly after the eighth opcode bit. It is ignored while status bit 0 is 1.
- R4: Opcode 0x01 is dropped unless the write-enable latch is 1 and status bit 0 is 0.
- R5: A write-status command commits only if chip select rises after exactly eight data bits. Fewer or more bits leave the status unchanged.
- R6: A commit sets status bit 0 to 1 for `WR_CYCLES` system clocks, after which it returns to 0.
- R7: At the end of the busy window the write-enable latch is cleared.
- R8: A commit copies data bit 7 into the lock bit (status bit 7) and data bits 5..2 into the protect field (status bits 5..2). Status bits 6, 1 and 0 are never taken from the data, and bit 6 always reads 0. The new values are visible from the commit onward.
- R9: If the lock bit is 1 and `wp_n` is low when chip select rises, the write-status command is refused. In that case the status, including the write-enable latch, is unchanged and no busy cycle starts.
- R10: Any other opcode is ignored until chip select rises. `spi_miso_oe` is high only while a read-status response is being sent.
- R11: Data is sampled on serial clock rises and sent on falls. A chip select rise in the middle of a byte discards the partial instruction, so the next low period decodes afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the device |
| wp_n | input | 1 | Active-low write-protect pin |
| spi_miso | output | 1 | Serial data out of the device |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; low means high impedance |

## Verification
Each SPI pin passes through two synchronizer stages and one edge-detect register. A serial clock edge therefore acts about three system clocks after the bench drives it. The bench holds every SPI half period for six system clocks. It samples `spi_miso` and `spi_miso_oe` at the end of each low phase, which is a full half period after the falling edge that updated them. Commits act about three clocks after chip select rises, and the bench waits twelve clocks before the next command. Each read-status response is captured within 200 clocks of its command. This keeps the first read inside the 1000-cycle busy window used by the bench, and repeated polling then confirms that bit 0 clears and the latch drops.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_WEN_ARM,
        ST_WR_DATA,
        ST_WR_ARM,
        ST_READ,
        ST_DROP
    } sr_state_e;

    localparam logic [7:0] OP_RD_STATUS = 8'h05;
    localparam logic [7:0] OP_WR_STATUS = 8'h01;
    localparam logic [7:0] OP_WR_ENABLE = 8'h06;

endpackage

// File: rtl/sr_pin_sync.sv
module sr_pin_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] q_prev_o
);
    localparam int DEPTH = STAGES + 1;

    logic [W-1:0] pipe_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) pipe_q[i] <= RST_VAL;
        end else begin
            pipe_q[0] <= d_i;
            for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign q_o      = pipe_q[STAGES-1];
    assign q_prev_o = pipe_q[STAGES];
endmodule

// File: rtl/sr_rx_shift.sv
module sr_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         din_i,
    output logic         done_o,
    output logic [W-1:0] value_o
);
    localparam int CW = $clog2(W);

    logic [W-2:0]  sh_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (shift_i) begin
            sh_q  <= {sh_q[W-3:0], din_i};
            cnt_q <= (cnt_q == CW'(W-1)) ? '0 : cnt_q + CW'(1);
        end
    end

    assign done_o  = shift_i && !clr_i && (cnt_q == CW'(W-1));
    assign value_o = {sh_q, din_i};
endmodule

// File: rtl/sr_busy_timer.sv
module sr_busy_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start_i) begin
            cnt_q  <= CW'(CYCLES - 1);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - CW'(1);
        end
    end

    assign busy_o = busy_q;
    assign done_o = busy_q && (cnt_q == '0) && !start_i;
endmodule

// File: rtl/sr_status_unit.sv
module sr_status_unit
    import sr_pkg::*;
#(
    parameter int WR_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    input  logic wp_n,
    output logic spi_miso,
    output logic spi_miso_oe
);
    localparam int BYTE_W = 8;
    localparam int BIT_CW = $clog2(BYTE_W);

    sr_state_e state_q, state_d;

    logic [2:0] pin_q, pin_prev;
    logic       cs_q, cs_rise, sclk_rise, sclk_fall, mosi_q;
    logic       rx_clr, rx_shift, byte_done;
    logic [7:0] byte_val;
    logic       wip, tmr_done, commit_wen, commit_wr, hw_locked;
    logic       wel_q, lock_q;
    logic [3:0] bp_q;
    logic [7:0] wr_byte_q, status;
    logic [6:0] tx_q;
    logic [BIT_CW-1:0] tx_cnt_q;
    logic       miso_q;

    sr_pin_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .d_i      ({spi_cs_n, spi_sclk, spi_mosi}),
        .q_o      (pin_q),
        .q_prev_o (pin_prev)
    );

    assign cs_q      = pin_q[2];
    assign cs_rise   = pin_q[2] & ~pin_prev[2];
    assign sclk_rise = ~cs_q & pin_q[1] & ~pin_prev[1];
    assign sclk_fall = ~cs_q & ~pin_q[1] & pin_prev[1];
    assign mosi_q    = pin_q[0];

    assign rx_clr   = cs_q || (state_q == ST_IDLE);
    assign rx_shift = sclk_rise && ((state_q == ST_OPCODE) || (state_q == ST_WR_DATA));

    sr_rx_shift #(.W(BYTE_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (rx_clr),
        .shift_i (rx_shift),
        .din_i   (mosi_q),
        .done_o  (byte_done),
        .value_o (byte_val)
    );

    assign hw_locked  = lock_q && !wp_n;
    assign commit_wen = cs_rise && (state_q == ST_WEN_ARM);
    assign commit_wr  = cs_rise && (state_q == ST_WR_ARM) && !hw_locked;

    sr_busy_timer #(.CYCLES(WR_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (commit_wr),
        .busy_o  (wip),
        .done_o  (tmr_done)
    );

    assign status = {lock_q, 1'b0, bp_q, wel_q, wip};

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = ST_OPCODE;
            ST_OPCODE:
                if (byte_done) begin
                    if (byte_val == OP_RD_STATUS)
                        state_d = ST_READ;
                    else if (byte_val == OP_WR_ENABLE)
                        state_d = wip ? ST_DROP : ST_WEN_ARM;
                    else if (byte_val == OP_WR_STATUS)
                        state_d = (wip || !wel_q) ? ST_DROP : ST_WR_DATA;
                    else
                        state_d = ST_DROP;
                end
            ST_WR_DATA: if (byte_done) state_d = ST_WR_ARM;
            ST_WEN_ARM,
            ST_WR_ARM:  if (sclk_rise) state_d = ST_DROP;
            ST_READ,
            ST_DROP:    state_d = state_q;
            default:    state_d = ST_IDLE;
        endcase
        if (cs_q) state_d = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and status storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q     <= 1'b0;
            lock_q    <= 1'b0;
            bp_q      <= '0;
            wr_byte_q <= '0;
            tx_q      <= '0;
            tx_cnt_q  <= '0;
            miso_q    <= 1'b0;
        end else begin
            if (commit_wen)    wel_q <= 1'b1;
            else if (tmr_done) wel_q <= 1'b0;

            if ((state_q == ST_WR_DATA) && byte_done) wr_byte_q <= byte_val;

            if (commit_wr) begin
                lock_q <= wr_byte_q[7];
                bp_q   <= wr_byte_q[5:2];
            end

            if (state_q != ST_READ) begin
                tx_cnt_q <= '0;
            end else if (sclk_fall) begin
                if (tx_cnt_q == '0) begin
                    miso_q <= status[7];
                    tx_q   <= status[6:0];
                end else begin
                    miso_q <= tx_q[6];
                    tx_q   <= {tx_q[5:0], 1'b0};
                end
                tx_cnt_q <= tx_cnt_q + BIT_CW'(1);
            end
        end
    end

    assign spi_miso    = miso_q;
    assign spi_miso_oe = (state_q == ST_READ);
endmodule

// File: rtl/sr_status_chk.sv
module sr_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_q,
    input logic       miso_oe,
    input logic       wip,
    input logic       wel,
    input logic       lock,
    input logic [3:0] bp,
    input logic       wp_n
);
    // R10
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q |=> !miso_oe);

    // R7
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);

    // R4
    busy_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> wel);

    // R8
    bits_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({lock, bp}) |-> $rose(wip));

    // R9
    hw_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> !($past(lock) && !$past(wp_n)));
endmodule

bind sr_status_unit sr_status_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_q    (cs_q),
    .miso_oe (spi_miso_oe),
    .wip     (wip),
    .wel     (wel_q),
    .lock    (lock_q),
    .bp      (bp_q),
    .wp_n    (wp_n)
);

// File: tb/sr_status_unit_tb.sv
`timescale 1ns/1ps
module sr_status_unit_tb;
    localparam int H         = 6;
    localparam int WR_CYCLES = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic wp_n = 1'b1;
    logic spi_miso, spi_miso_oe;

    int n_run = 0;
    int n_fail = 0;
    bit oe_seen;

    always #4 clk = ~clk;

    sr_status_unit #(.WR_CYCLES(WR_CYCLES)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sclk    (spi_sclk),
        .spi_cs_n    (spi_cs_n),
        .spi_mosi    (spi_mosi),
        .wp_n        (wp_n),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin();
        spi_cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic cs_end();
        wait_clk(H);
        spi_cs_n = 1'b1;
        wait_clk(2*H);
    endtask

    task automatic clk_bit(input logic b, output logic r);
        spi_mosi = b;
        wait_clk(H);
        r = spi_miso;
        if (spi_miso_oe) oe_seen = 1'b1;
        spi_sclk = 1'b1;
        wait_clk(H);
        spi_sclk = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] v, input int nbits, output logic [7:0] got);
        logic r;
        got = '0;
        for (int i = 0; i < nbits; i++) begin
            clk_bit(v[7 - (i % 8)], r);
            got = {got[6:0], r};
        end
    endtask

    task automatic wren(input int nbits);
        logic [7:0] g;
        cs_begin();
        send_bits(8'h06, nbits, g);
        cs_end();
    endtask

    task automatic wrsr(input logic [7:0] d, input int data_bits);
        logic [7:0] g;
        cs_begin();
        send_bits(8'h01, 8, g);
        send_bits(d, data_bits, g);
        cs_end();
    endtask

    task automatic rdsr(output logic [7:0] b0, output logic [7:0] b1);
        logic [7:0] g;
        cs_begin();
        send_bits(8'h05, 8, g);
        oe_seen = 1'b0;
        send_bits(8'h00, 8, b0);
        send_bits(8'h00, 8, b1);
        cs_end();
    endtask

    task automatic poll_idle(output logic [7:0] last);
        logic [7:0] b1;
        last = 8'h01;
        for (int k = 0; k < 20 && last[0]; k++) rdsr(last, b1);
    endtask

    task automatic t_reset();
        logic [7:0] a, b;
        chk("R1 oe at reset", {7'd0, spi_miso_oe}, 8'h00);
        rdsr(a, b);
        chk("R1 status at reset", a, 8'h00);
        chk("R2 repeated byte", b, 8'h00);
        chk("R10 oe during read", {7'd0, oe_seen}, 8'h01);
        chk("R10 oe with cs high", {7'd0, spi_miso_oe}, 8'h00);
    endtask

    task automatic t_no_wel();
        logic [7:0] a, b;
        wrsr(8'hBC, 8);
        rdsr(a, b);
        chk("R4 write without latch", a, 8'h00);
    endtask

    task automatic t_write_cycle();
        logic [7:0] a, b;
        wren(8);
        rdsr(a, b);
        chk("R3 latch set", a, 8'h02);
        wrsr(8'hFF, 8);
        rdsr(a, b);
        chk("R6 R8 busy status", a, 8'hBF);
        chk("R2 repeat during busy", b, 8'hBF);
        wren(8);
        poll_idle(a);
        chk("R7 R3 after cycle", a, 8'hBC);
    endtask

    task automatic t_cancel();
        logic [7:0] a, b;
        wren(9);
        rdsr(a, b);
        chk("R3 extra bit cancels", a, 8'hBC);
        wren(8);
        wrsr(8'h00, 9);
        rdsr(a, b);
        chk("R5 nine data bits", a, 8'hBE);
        wrsr(8'h00, 7);
        rdsr(a, b);
        chk("R5 seven data bits", a, 8'hBE);
    endtask

    task automatic t_protect();
        logic [7:0] a, b;
        wp_n = 1'b0;
        wrsr(8'h00, 8);
        rdsr(a, b);
        chk("R9 refused when locked", a, 8'hBE);
        wp_n = 1'b1;
        wrsr(8'h00, 8);
        rdsr(a, b);
        chk("R9 R6 accepted with pin high", a, 8'h03);
        poll_idle(a);
        chk("R6 R7 cycle end", a, 8'h00);
        wp_n = 1'b0;
        wren(8);
        wrsr(8'h84, 8);
        rdsr(a, b);
        chk("R9 pin low but unlocked", a, 8'h87);
        poll_idle(a);
        chk("R8 final bits", a, 8'h84);
        wp_n = 1'b1;
    endtask

    task automatic t_unknown();
        logic [7:0] a, b;
        cs_begin();
        send_bits(8'h9F, 8, a);
        oe_seen = 1'b0;
        send_bits(8'h05, 8, a);
        send_bits(8'h06, 8, a);
        cs_end();
        chk("R10 unknown opcode no drive", {7'd0, oe_seen}, 8'h00);
        cs_begin();
        send_bits(8'h06, 4, a);
        spi_cs_n = 1'b1;
        wait_clk(2*H);
        rdsr(a, b);
        chk("R11 partial opcode discarded", a, 8'h84);
        chk("R2 stream copy", b, 8'h84);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_no_wel();
        t_write_cycle();
        t_cancel();
        t_protect();
        t_unknown();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule